// File: doc/BRIEF.md
# Overlay Memory Address Decoder

This block sits between a DSP core and its memories. It takes a 14-bit core address and a space select, either program or data, and decides where the access goes. The possible targets are on-chip RAM, a bank of 32 memory-mapped control registers, or one of two external overlay pages. In each space, one 8K half of the 16K-word map is fixed. The other half is switchable, and a small overlay register chooses what it maps to. A boot-mode pin swaps the fixed and switchable roles in program space.

For external targets, the block builds the external address from the page number and the low 13 address bits. It raises a chip select and read or write strobes. External data accesses are stretched by the number of wait states held in a data wait register, and the core is stalled for that many cycles. Internal accesses finish in one cycle. Reserved overlay settings are decoded as internal and flagged.

Top module: `overlayDecoder`

## Requirements
- R1: In program space with `bootMode` low, addresses 0x0000–0x1FFF always go to internal RAM. Addresses 0x2000–0x3FFF go to internal RAM when `pmPage` is 0, external page 1 when it is 1, and external page 2 when it is 2.
- R2: For an external access, `extAddr[13]` is 0 for page 1 and 1 for page 2, and `extAddr[12:0]` equals `coreAddr[12:0]`. While no external access is requested, `extAddr` is zero.
- R3: In program space with `bootMode` high and `pmPage` 0, addresses 0x0000–0x1FFF are external with `extAddr[13]` = 0, and 0x2000–0x3FFF are internal RAM.
- R4: In data space, 0x2000–0x3FDF goes to internal RAM. 0x3FE0–0x3FFF asserts `regSel` and leaves `intRamEn` low.
- R5: In data space, 0x0000–0x1FFF follows `dmPage` with the same encoding as `pmPage` (0 internal, 1 page 1, 2 page 2). `dmPage` has no effect on 0x2000–0x3FFF.
- R6: An internal RAM or register access never asserts `stall`, whatever the value of `dataWait`.
- R7: An external data access with `dataWait` = N holds `stall` high for exactly N cycles, starting with the first cycle of the request. `extCs` stays high for N+1 cycles. N is sampled in the first cycle, so later changes to `dataWait` do not affect the access in progress. A new external access that starts in the cycle right after a completion stalls again.
- R8: External program-space accesses take no wait states and never assert `stall`.
- R9: The following settings are reserved: overlay value 3, and a nonzero `pmPage` while `bootMode` is high (program space only). An access that hits a reserved setting goes to internal RAM and asserts `decodeErr`. Data-space decoding ignores `pmPage`.
- R10: With `rdReq` and `wrReq` both low, `intRamEn`, `regSel`, `extCs`, `extRd`, `extWr`, `stall` and `decodeErr` are all low.
- R11: After reset with no request pending, `stall` is low and no target is selected.
- R12: `extRd` and `extWr` follow `rdReq` and `wrReq` for external targets. `extCs` is high when either is high. At most one of `intRamEn`, `regSel` and `extCs` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreAddr | input | 14 | Core word address |
| spaceSel | input | 1 | 0 = program space, 1 = data space |
| rdReq | input | 1 | Core read request |
| wrReq | input | 1 | Core write request |
| pmPage | input | 2 | Program overlay selection |
| dmPage | input | 2 | Data overlay selection |
| bootMode | input | 1 | Mode pin that swaps the program halves |
| dataWait | input | 3 | Wait states for external data accesses |
| intRamEn | output | 1 | Internal RAM enable |
| regSel | output | 1 | Memory-mapped register select |
| extAddr | output | 14 | External address bus |
| extCs | output | 1 | External chip select |
| extRd | output | 1 | External read strobe |
| extWr | output | 1 | External write strobe |
| stall | output | 1 | Core stall |
| decodeErr | output | 1 | Reserved overlay setting hit |

## Verification
The wait-state counter finishing one external data access and the decoder starting the next one can fall in the same clock edge. The bench provokes this by keeping an external data request asserted through the completion cycle while `dataWait` is raised in mid-access. It then judges two things. The first access must still stall for the count sampled at its start. The following access must stall again, in the very next cycle, for the new count. Overlay decoding is covered separately: a vector table is walked with zero wait states, so every decode result is visible in a single cycle.

// File: rtl/overlayDecoderPkg.sv
package overlayDecoderPkg;

  typedef enum logic [1:0] {
    RGN_INT = 2'd0,
    RGN_MMR = 2'd1,
    RGN_EXT = 2'd2
  } regionT;

  typedef struct packed {
    regionT region;
    logic   extHi;
    logic   rsvd;
  } decodeT;

  typedef struct packed {
    logic ramEn;
    logic regSel;
    logic extCs;
    logic extRd;
    logic extWr;
    logic stall;
  } strobeT;

endpackage

// File: rtl/overlayDecoderPath.sv
module overlayDecoderPath
  import overlayDecoderPkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OVL_W     = 2,
  parameter int MMR_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              spaceSel,
  input  logic              access,
  input  logic [OVL_W-1:0]  pmPage,
  input  logic [OVL_W-1:0]  dmPage,
  input  logic              bootMode,
  output decodeT            dec,
  output logic [ADDR_W-1:0] extAddr
);

  localparam int HALF_W    = ADDR_W - 1;
  localparam int MMR_START = (1 << ADDR_W) - MMR_WORDS;

  logic upperHalf;
  assign upperHalf = coreAddr[ADDR_W-1];

  // Maps an overlay value to a target for the switchable half.
  function automatic decodeT pageMap(input logic [OVL_W-1:0] page);
    decodeT d;
    d = '{region: RGN_INT, extHi: 1'b0, rsvd: 1'b0};
    if (page == OVL_W'(0)) begin
      d.region = RGN_INT;
    end else if (page == OVL_W'(1)) begin
      d.region = RGN_EXT;
      d.extHi  = 1'b0;
    end else if (page == OVL_W'(2)) begin
      d.region = RGN_EXT;
      d.extHi  = 1'b1;
    end else begin
      d.rsvd = 1'b1;
    end
    return d;
  endfunction

  always_comb begin
    dec = '{region: RGN_INT, extHi: 1'b0, rsvd: 1'b0};
    if (!spaceSel) begin
      if (bootMode) begin
        if (pmPage != '0) dec.rsvd = 1'b1;
        else if (!upperHalf) dec.region = RGN_EXT;
      end else if (upperHalf) begin
        dec = pageMap(pmPage);
      end
    end else begin
      if (upperHalf) begin
        if (coreAddr >= ADDR_W'(MMR_START)) dec.region = RGN_MMR;
      end else begin
        dec = pageMap(dmPage);
      end
    end
  end

  always_comb begin
    if (access && dec.region == RGN_EXT)
      extAddr = {dec.extHi, coreAddr[HALF_W-1:0]};
    else
      extAddr = '0;
  end

  AST_MMR_WINDOW: assert property (@(posedge clk) disable iff (!rstN) (dec.region == RGN_MMR) |-> (spaceSel && upperHalf)); // R4
  AST_RSVD_INTERNAL: assert property (@(posedge clk) disable iff (!rstN) dec.rsvd |-> (dec.region == RGN_INT)); // R9
  AST_PAGE_TWO_HI: assert property (@(posedge clk) disable iff (!rstN) (access && !spaceSel && !bootMode && pmPage == OVL_W'(2) && upperHalf) |-> extAddr[ADDR_W-1]); // R2

endmodule

// File: rtl/overlayDecoderCtrl.sv
module overlayDecoderCtrl
  import overlayDecoderPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              spaceSel,
  input  regionT            region,
  input  logic [WAIT_W-1:0] dataWait,
  output strobeT            stb
);

  logic              busy;
  logic [WAIT_W-1:0] remain;
  logic              access;
  logic              isExt;
  logic              startWait;

  always_comb begin
    access     = rdReq | wrReq;
    isExt      = access && (region == RGN_EXT);
    startWait  = !busy && isExt && spaceSel && (dataWait != '0);
    stb.ramEn  = access && (region == RGN_INT);
    stb.regSel = access && (region == RGN_MMR);
    stb.extCs  = isExt;
    stb.extRd  = rdReq && (region == RGN_EXT);
    stb.extWr  = wrReq && (region == RGN_EXT);
    stb.stall  = busy ? (remain != '0) : startWait;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end else if (startWait) begin
      busy   <= 1'b1;
      remain <= dataWait - 1'b1;
    end
  end

  AST_INT_NO_STALL: assert property (@(posedge clk) disable iff (!rstN) (!busy && access && region != RGN_EXT) |-> !stb.stall); // R6
  AST_PROG_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN) (access && !spaceSel) |-> !stb.stall); // R8
  AST_STALL_WITH_CS: assert property (@(posedge clk) disable iff (!rstN) stb.stall |-> stb.extCs); // R7
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rstN) (busy && remain == '0) |-> !stb.stall); // R7
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN) $onehot0({stb.ramEn, stb.regSel, stb.extCs})); // R12

endmodule

// File: rtl/overlayDecoder.sv
module overlayDecoder
  import overlayDecoderPkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OVL_W     = 2,
  parameter int WAIT_W    = 3,
  parameter int MMR_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              spaceSel,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [OVL_W-1:0]  pmPage,
  input  logic [OVL_W-1:0]  dmPage,
  input  logic              bootMode,
  input  logic [WAIT_W-1:0] dataWait,
  output logic              intRamEn,
  output logic              regSel,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extCs,
  output logic              extRd,
  output logic              extWr,
  output logic              stall,
  output logic              decodeErr
);

  decodeT dec;
  strobeT stb;
  logic   access;

  assign access = rdReq | wrReq;

  overlayDecoderPath #(
    .ADDR_W(ADDR_W), .OVL_W(OVL_W), .MMR_WORDS(MMR_WORDS)
  ) uPath (
    .clk(clk), .rstN(rstN), .coreAddr(coreAddr), .spaceSel(spaceSel),
    .access(access), .pmPage(pmPage), .dmPage(dmPage), .bootMode(bootMode),
    .dec(dec), .extAddr(extAddr)
  );

  overlayDecoderCtrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq),
    .spaceSel(spaceSel), .region(dec.region), .dataWait(dataWait), .stb(stb)
  );

  assign intRamEn  = stb.ramEn;
  assign regSel    = stb.regSel;
  assign extCs     = stb.extCs;
  assign extRd     = stb.extRd;
  assign extWr     = stb.extWr;
  assign stall     = stb.stall;
  assign decodeErr = access && dec.rsvd;

endmodule

// File: tb/overlayDecoder_test.sv
module overlayDecoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] coreAddr = '0;
  logic        spaceSel = 1'b0;
  logic        rdReq = 1'b0;
  logic        wrReq = 1'b0;
  logic [1:0]  pmPage = '0;
  logic [1:0]  dmPage = '0;
  logic        bootMode = 1'b0;
  logic [2:0]  dataWait = '0;
  logic        intRamEn, regSel, extCs, extRd, extWr, stall, decodeErr;
  logic [13:0] extAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  overlayDecoder uut (
    .clk(clk), .rstN(rstN), .coreAddr(coreAddr), .spaceSel(spaceSel),
    .rdReq(rdReq), .wrReq(wrReq), .pmPage(pmPage), .dmPage(dmPage),
    .bootMode(bootMode), .dataWait(dataWait), .intRamEn(intRamEn),
    .regSel(regSel), .extAddr(extAddr), .extCs(extCs), .extRd(extRd),
    .extWr(extWr), .stall(stall), .decodeErr(decodeErr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [13:0] addr;
    logic        space;
    logic        rd;
    logic        wr;
    logic [1:0]  pm;
    logic [1:0]  dm;
    logic        boot;
    logic        ram;
    logic        regs;
    logic        cs;
    logic        erd;
    logic        ewr;
    logic        err;
    logic [13:0] ext;
  } vecT;

  // req, addr, space, rd, wr, pm, dm, boot | ram, regs, cs, erd, ewr, err, ext
  localparam vecT VECS [NVEC] = '{
    '{4'd1,  14'h0123, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R1
    '{4'd1,  14'h2ABC, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R1
    '{4'd2,  14'h2ABC, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0ABC}, // R2
    '{4'd2,  14'h3FFF, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 14'h3FFF}, // R2
    '{4'd1,  14'h1000, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R1
    '{4'd3,  14'h0456, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0456}, // R3
    '{4'd3,  14'h2456, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R3
    '{4'd4,  14'h3FDF, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R4
    '{4'd4,  14'h3FE0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R4
    '{4'd4,  14'h3FFF, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R4
    '{4'd5,  14'h0010, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R5
    '{4'd5,  14'h1FFF, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 14'h1FFF}, // R5
    '{4'd5,  14'h0001, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h2001}, // R5
    '{4'd5,  14'h2001, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R5
    '{4'd9,  14'h2100, 1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000}, // R9
    '{4'd9,  14'h0100, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000}, // R9
    '{4'd9,  14'h0100, 1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000}, // R9
    '{4'd10, 14'h2ABC, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R10
    '{4'd9,  14'h0100, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000}, // R9
    '{4'd9,  14'h0005, 1'b1, 1'b1, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0005}  // R9
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] a, input logic sp, input logic r, input logic w,
                       input logic [1:0] pm, input logic [1:0] dm, input logic bm, input logic [2:0] wt);
    coreAddr = a; spaceSel = sp; rdReq = r; wrReq = w;
    pmPage = pm; dmPage = dm; bootMode = bm; dataWait = wt;
  endtask

  task automatic nextCycle();
    @(negedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int stallCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nextCycle();
    // R11: quiet after reset
    check("R11", "stall", stall, 0);
    check("R11", "targets", {intRamEn, regSel, extCs}, 0);

    // Decode table, zero wait states
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      @(negedge clk);
      drive(VECS[i].addr, VECS[i].space, VECS[i].rd, VECS[i].wr,
            VECS[i].pm, VECS[i].dm, VECS[i].boot, 3'd0);
      #1;
      tag = $sformatf("R%0d", VECS[i].req);
      check(tag, $sformatf("vec%0d ramEn", i), intRamEn, VECS[i].ram);
      check(tag, $sformatf("vec%0d regSel", i), regSel, VECS[i].regs);
      check(tag, $sformatf("vec%0d extCs", i), extCs, VECS[i].cs);
      check("R12", $sformatf("vec%0d extRd", i), extRd, VECS[i].erd);
      check("R12", $sformatf("vec%0d extWr", i), extWr, VECS[i].ewr);
      check(tag, $sformatf("vec%0d decodeErr", i), decodeErr, VECS[i].err);
      check("R2", $sformatf("vec%0d extAddr", i), extAddr, VECS[i].ext);
      check("R6", $sformatf("vec%0d stall", i), stall, 0);
    end

    // R7: three wait states, with dataWait raised in mid-access
    @(negedge clk);
    drive(14'h0042, 1'b1, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0, 3'd3);
    #1;
    check("R7", "n3 c0 stall", stall, 1);
    check("R7", "n3 c0 extRd", extRd, 1);
    nextCycle();
    dataWait = 3'd7;
    check("R7", "n3 c1 stall", stall, 1);
    nextCycle();
    check("R7", "n3 c2 stall", stall, 1);
    check("R7", "n3 c2 extAddr", extAddr, 14'h0042);
    nextCycle();
    check("R7", "n3 c3 stall", stall, 0);
    check("R7", "n3 c3 extCs", extCs, 1);
    // Back-to-back: request held, new access with seven wait states
    nextCycle();
    stallCnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (!stall) break;
      if (!extCs) break;
      stallCnt++;
      nextCycle();
    end
    check("R7", "back-to-back stall cycles", stallCnt, 7);
    check("R7", "b2b final extCs", extCs, 1);

    // R7: one wait state on a write
    @(negedge clk);
    drive(14'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd1);
    nextCycle();
    drive(14'h1234, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 3'd1);
    #1;
    check("R7", "n1 c0 stall", stall, 1);
    check("R7", "n1 c0 extWr", extWr, 1);
    check("R7", "n1 extAddr", extAddr, 14'h3234);
    nextCycle();
    check("R7", "n1 c1 stall", stall, 0);
    check("R7", "n1 c1 extWr", extWr, 1);

    // R6: internal accesses ignore dataWait
    @(negedge clk);
    drive(14'h3FF0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 3'd5);
    #1;
    check("R6", "mmr stall", stall, 0);
    check("R6", "mmr regSel", regSel, 1);
    nextCycle();
    coreAddr = 14'h2100;
    #1;
    check("R6", "ram stall", stall, 0);
    nextCycle();
    check("R6", "ram stall next", stall, 0);

    // R8: external program access takes no wait states
    @(negedge clk);
    drive(14'h2222, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 3'd5);
    #1;
    check("R8", "prog ext stall", stall, 0);
    check("R8", "prog ext extCs", extCs, 1);
    check("R8", "prog ext extAddr", extAddr, 14'h2222);
    nextCycle();
    check("R8", "prog ext stall next", stall, 0);

    // R10: request dropped
    @(negedge clk);
    rdReq = 1'b0;
    #1;
    check("R10", "idle outputs", {intRamEn, regSel, extCs, extRd, extWr, stall, decodeErr}, 0);
    check("R10", "idle extAddr", extAddr, 0);

    finish();
  end

endmodule